// File: doc/BRIEF.md
# Bit-Oriented Receive Aligner with Collision Capture

This block sits behind a contactless receiver during an anticollision exchange. It turns a serial stream of received bits into bytes for a FIFO write port. The first bit of a frame can be placed at any bit position of the first byte, so a frame that resumes a partly known identifier lines up with the bits already held. Bytes are filled least significant bit first. Each completed byte is written out in the cycle after its last bit arrives. An end-of-frame pulse writes out a partly filled last byte, together with a count of how many of its positions are filled.

The block also watches a per-bit collision strobe. It keeps the position of the first collision in the frame, counted from 1 at the aligned first bit. A flag marks that position as unusable when there was no collision or when the count does not fit in the position field. A control input chooses between two ways of storing the bits that follow the first collision: they are forced to zero, or they are stored as received.

Top module: `rx_bit_aligner`

## Requirements
- R1: A start pulse loads `align_i`. The first bit received after it is stored at bit position `align_i` (0 to 7) of the first byte.
- R2: Each later bit is stored at the next higher position, least significant bit first. After position 7, the next bit goes to bit 0 of the next byte, which is written with `wr_bits_o` = 0 (all 8 bits valid).
- R3: `wr_o` is high for exactly one cycle. It rises in the cycle after the bit that fills position 7 is accepted.
- R4: In the first byte of a frame, positions below `align_i` are written as 0.
- R5: When `keep_after_coll_i` is 0, every bit accepted after the first collision is stored as 0. The colliding bit keeps its received value. When `keep_after_coll_i` is 1, all bits are stored as received.
- R6: Only the first collision of a frame is captured. Later collision strobes leave `coll_pos_o` unchanged.
- R7: The collision position is the 1-based count of the colliding bit, counted from the aligned first bit. When that count is 31 or less, `coll_pos_o` takes the count and `coll_pos_inv_o` goes to 0 in the next cycle.
- R8: When the first collision has a count above 31, `coll_pos_inv_o` stays 1 and `coll_pos_o` stays 0.
- R9: A start pulse clears the bit count, the collision state and any partly filled byte, which is never written. It sets `coll_pos_inv_o` to 1. A bit or collision presented in the start cycle is ignored.
- R10: An `eof_i` pulse with `bit_vld_i` low writes out a partly filled byte in the next cycle. `wr_bits_o` then gives the number of filled positions, `(align + bits) mod 8`. No write happens when no bit is pending.
- R11: After reset, `wr_o` is 0, `coll_pos_o` is 0 and `coll_pos_inv_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start pulse |
| align_i | input | ALIGN_W | Bit position of the first received bit |
| keep_after_coll_i | input | 1 | 1: keep bits after a collision; 0: store them as 0 |
| bit_vld_i | input | 1 | A received bit is present this cycle |
| bit_dat_i | input | 1 | Received bit value |
| bit_coll_i | input | 1 | The present bit had a collision |
| eof_i | input | 1 | End of frame; write out the partial byte |
| wr_o | output | 1 | FIFO write strobe |
| wr_data_o | output | 2**ALIGN_W | Byte to be written |
| wr_bits_o | output | ALIGN_W | Filled positions in the written byte; 0 means all |
| coll_pos_o | output | POS_W | 1-based position of the first collision |
| coll_pos_inv_o | output | 1 | Collision position is not valid |

## Verification
The bench builds the block with its default parameters: a 3-bit alignment, and therefore 8-bit bytes, with a 5-bit position field. This small setup lets it sweep every alignment against frame lengths that stop short of, land exactly on, and run past byte boundaries. Each of these is combined with no collision, an early collision, a mid-frame collision and a last-bit collision, in both storage modes. The 5-bit field means a 40-bit frame is enough to place a first collision just inside and just outside the position range, and to check that a restarted frame discards its partial byte.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

   typedef enum logic [1:0] {
      EV_IDLE  = 2'd0,
      EV_START = 2'd1,
      EV_BIT   = 2'd2,
      EV_EOF   = 2'd3
   } rxa_ev_e;

   // start outranks a bit, a bit outranks end-of-frame
   function automatic rxa_ev_e rxa_decode(input logic start, input logic vld, input logic eof);
      if (start)    return EV_START;
      else if (vld) return EV_BIT;
      else if (eof) return EV_EOF;
      else          return EV_IDLE;
   endfunction

endpackage

// File: rtl/rxa_coll_track.sv
module rxa_coll_track
   import rxa_pkg::*;
#(
   parameter int POS_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rxa_ev_e          ev_i,
   input  logic             coll_i,
   output logic             seen_o,
   output logic [POS_W-1:0] pos_o,
   output logic             inv_o
);
   localparam int                CNT_W   = POS_W + 1;
   localparam logic [CNT_W-1:0]  CNT_MAX = '1;
   localparam logic [CNT_W-1:0]  POS_LIM = CNT_W'((1 << POS_W) - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             seen_q;

   // saturating count keeps the out-of-range case sticky
   assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
         pos_o  <= '0;
         inv_o  <= 1'b1;
      end else begin
         case (ev_i)
            EV_START: begin
               cnt_q  <= '0;
               seen_q <= 1'b0;
               pos_o  <= '0;
               inv_o  <= 1'b1;
            end
            EV_BIT: begin
               cnt_q <= cnt_inc;
               if (coll_i && !seen_q) begin
                  seen_q <= 1'b1;
                  if (cnt_inc <= POS_LIM) begin
                     pos_o <= cnt_inc[POS_W-1:0];
                     inv_o <= 1'b0;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign seen_o = seen_q;

endmodule

// File: rtl/rxa_byte_pack.sv
module rxa_byte_pack
   import rxa_pkg::*;
#(
   parameter int ALIGN_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  rxa_ev_e            ev_i,
   input  logic [ALIGN_W-1:0] align_i,
   input  logic               bit_i,
   output logic               wr_o,
   output logic [(1<<ALIGN_W)-1:0] data_o,
   output logic [ALIGN_W-1:0] bits_o
);
   localparam int                 BYTE_W = 1 << ALIGN_W;
   localparam logic [ALIGN_W-1:0] TOP    = ALIGN_W'(BYTE_W - 1);

   logic [ALIGN_W-1:0] ptr_q;
   logic [BYTE_W-1:0]  buf_q;
   logic [BYTE_W-1:0]  buf_nxt;
   logic               part_q;

   // one insertion mux per bit slot
   for (genvar b = 0; b < BYTE_W; b++) begin : g_slot
      assign buf_nxt[b] = (ptr_q == ALIGN_W'(b)) ? bit_i : buf_q[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         buf_q  <= '0;
         part_q <= 1'b0;
         wr_o   <= 1'b0;
         data_o <= '0;
         bits_o <= '0;
      end else begin
         wr_o <= 1'b0;
         case (ev_i)
            EV_START: begin
               ptr_q  <= align_i;
               buf_q  <= '0;
               part_q <= 1'b0;
            end
            EV_BIT: begin
               if (ptr_q == TOP) begin
                  wr_o   <= 1'b1;
                  data_o <= buf_nxt;
                  bits_o <= '0;
                  buf_q  <= '0;
                  ptr_q  <= '0;
                  part_q <= 1'b0;
               end else begin
                  buf_q  <= buf_nxt;
                  ptr_q  <= ptr_q + 1'b1;
                  part_q <= 1'b1;
               end
            end
            EV_EOF: begin
               if (part_q) begin
                  wr_o   <= 1'b1;
                  data_o <= buf_q;
                  bits_o <= ptr_q;
               end
               buf_q  <= '0;
               ptr_q  <= '0;
               part_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/rx_bit_aligner.sv
module rx_bit_aligner
   import rxa_pkg::*;
#(
   parameter int ALIGN_W  = 3,
   parameter int POS_W    = 5,
   parameter bit CLEAR_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [ALIGN_W-1:0]      align_i,
   input  logic                    keep_after_coll_i,
   input  logic                    bit_vld_i,
   input  logic                    bit_dat_i,
   input  logic                    bit_coll_i,
   input  logic                    eof_i,
   output logic                    wr_o,
   output logic [(1<<ALIGN_W)-1:0] wr_data_o,
   output logic [ALIGN_W-1:0]      wr_bits_o,
   output logic [POS_W-1:0]        coll_pos_o,
   output logic                    coll_pos_inv_o
);
   if (ALIGN_W < 1 || ALIGN_W > 6) begin : g_bad_align
      $error("ALIGN_W out of range");
   end
   if (POS_W < 2 || POS_W > 16) begin : g_bad_pos
      $error("POS_W out of range");
   end

   rxa_ev_e ev;
   logic    seen;
   logic    stored_bit;

   assign ev = rxa_decode(start_i, bit_vld_i, eof_i);

   // blanking after the first collision is an optional variant
   if (CLEAR_EN) begin : g_blank
      assign stored_bit = bit_dat_i & (keep_after_coll_i | ~seen);
   end else begin : g_pass
      assign stored_bit = bit_dat_i;
   end

   rxa_coll_track #(.POS_W(POS_W)) u_coll (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_i   (ev),
      .coll_i (bit_coll_i),
      .seen_o (seen),
      .pos_o  (coll_pos_o),
      .inv_o  (coll_pos_inv_o)
   );

   rxa_byte_pack #(.ALIGN_W(ALIGN_W)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_i    (ev),
      .align_i (align_i),
      .bit_i   (stored_bit),
      .wr_o    (wr_o),
      .data_o  (wr_data_o),
      .bits_o  (wr_bits_o)
   );

endmodule

// File: rtl/rxa_checker.sv
module rxa_checker #(
   parameter int ALIGN_W = 3,
   parameter int POS_W   = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start_i,
   input logic                    bit_vld_i,
   input logic                    eof_i,
   input logic                    wr_o,
   input logic [ALIGN_W-1:0]      wr_bits_o,
   input logic [POS_W-1:0]        coll_pos_o,
   input logic                    coll_pos_inv_o
);
   p_wr_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |=> !wr_o);

   p_wr_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |-> $past(bit_vld_i || eof_i));

   p_partial_needs_eof_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_o && wr_bits_o != '0) |-> $past(eof_i && !bit_vld_i && !start_i));

   p_start_resets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (coll_pos_inv_o && !wr_o && coll_pos_o == '0));

   p_first_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!coll_pos_inv_o && !start_i) |=> ($stable(coll_pos_o) && !coll_pos_inv_o));

   p_inv_zero_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
      coll_pos_inv_o |-> coll_pos_o == '0);
endmodule

bind rx_bit_aligner rxa_checker #(.ALIGN_W(ALIGN_W), .POS_W(POS_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .start_i        (start_i),
   .bit_vld_i      (bit_vld_i),
   .eof_i          (eof_i),
   .wr_o           (wr_o),
   .wr_bits_o      (wr_bits_o),
   .coll_pos_o     (coll_pos_o),
   .coll_pos_inv_o (coll_pos_inv_o)
);

// File: tb/tb_rx_bit_aligner.sv
module tb_rx_bit_aligner;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [2:0] align_i = '0;
   logic       keep_i = 1'b1;
   logic       bit_vld_i = 1'b0;
   logic       bit_dat_i = 1'b0;
   logic       bit_coll_i = 1'b0;
   logic       eof_i = 1'b0;
   logic       wr_o;
   logic [7:0] wr_data_o;
   logic [2:0] wr_bits_o;
   logic [4:0] coll_pos_o;
   logic       coll_pos_inv_o;

   always #10 clk = ~clk;

   rx_bit_aligner dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .align_i(align_i),
      .keep_after_coll_i(keep_i), .bit_vld_i(bit_vld_i), .bit_dat_i(bit_dat_i),
      .bit_coll_i(bit_coll_i), .eof_i(eof_i), .wr_o(wr_o), .wr_data_o(wr_data_o),
      .wr_bits_o(wr_bits_o), .coll_pos_o(coll_pos_o), .coll_pos_inv_o(coll_pos_inv_o)
   );

   int n_chk = 0;
   int n_err = 0;

   logic       pend = 1'b0;
   logic [7:0] pend_d = '0;
   logic [2:0] pend_b = '0;
   string      pend_tag = "R3";

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // called at a falling edge: compares the write port with the pending expectation
   task automatic check_wr();
      chk(wr_o == pend, "R3", "write strobe", int'(wr_o), int'(pend));
      if (pend && wr_o) begin
         chk(wr_data_o == pend_d, pend_tag, "write data", int'(wr_data_o), int'(pend_d));
         chk(wr_bits_o == pend_b, pend_tag, "write bit count", int'(wr_bits_o), int'(pend_b));
      end
      pend = 1'b0;
   endtask

   function automatic logic pat(input int i, input int al);
      return ((i * 3 + al + (i >> 2)) % 3) == 0;
   endfunction

   // c, c2: 0-based bit indices of collisions, -1 for none
   task automatic run_frame(input int al, input int n, input int c, input int c2, input bit keep);
      logic [7:0] eb;
      bit         seen;
      bit         first;
      int         p;
      logic       st;
      int         ep;
      bit         einv;
      string      ctag;
      eb = '0; seen = 0; first = 1;
      @(negedge clk);
      check_wr();
      // R9: bit and collision offered together with start must be dropped
      start_i = 1'b1; align_i = 3'(al); keep_i = keep;
      bit_vld_i = 1'b1; bit_dat_i = 1'b1; bit_coll_i = 1'b1; eof_i = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check_wr();
         start_i = 1'b0;
         bit_vld_i = 1'b1;
         bit_dat_i = pat(i, al);
         bit_coll_i = (i == c) || (i == c2);
         st = (seen && !keep) ? 1'b0 : pat(i, al);
         if (i == c) seen = 1;
         p = (al + i) % 8;
         eb[p] = st;
         if (p == 7) begin
            pend = 1'b1; pend_d = eb; pend_b = 3'd0;
            pend_tag = (c >= 0 && !keep) ? "R5" : (first ? "R1,R4" : "R2");
            first = 0;
            eb = '0;
         end
      end
      @(negedge clk);
      check_wr();
      bit_vld_i = 1'b0; bit_coll_i = 1'b0; bit_dat_i = 1'b0; eof_i = 1'b1;
      if ((al + n) % 8 != 0) begin
         pend = 1'b1; pend_d = eb; pend_b = 3'((al + n) % 8);
         pend_tag = (c >= 0 && !keep) ? "R5" : (first ? "R1,R4" : "R10");
      end
      @(negedge clk);
      check_wr();
      eof_i = 1'b0;
      @(negedge clk);
      check_wr();
      if (c < 0 || c + 1 > 31) begin ep = 0; einv = 1; end
      else begin ep = c + 1; einv = 0; end
      if (c < 0)           ctag = "R9";
      else if (c + 1 > 31) ctag = "R8";
      else if (c2 >= 0)    ctag = "R6";
      else                 ctag = "R7";
      chk(coll_pos_inv_o == einv, ctag, "position invalid flag", int'(coll_pos_inv_o), int'(einv));
      chk(coll_pos_o == 5'(ep), ctag, "collision position", int'(coll_pos_o), ep);
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: state right after reset
      chk(wr_o == 1'b0, "R11", "write strobe in reset", int'(wr_o), 0);
      chk(coll_pos_o == 5'd0, "R11", "position in reset", int'(coll_pos_o), 0);
      chk(coll_pos_inv_o == 1'b1, "R11", "invalid flag in reset", int'(coll_pos_inv_o), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(coll_pos_inv_o == 1'b1, "R11", "invalid flag after reset", int'(coll_pos_inv_o), 1);

      for (int al = 0; al < 8; al++) begin
         for (int li = 0; li < 5; li++) begin
            int n;
            n = (li == 0) ? 1 : (li == 1) ? 5 : (li == 2) ? 8 : (li == 3) ? 12 : 17;
            for (int ci = 0; ci < 4; ci++) begin
               int c;
               int c2;
               c = (ci == 0) ? -1 : (ci == 1) ? 0 : (ci == 2) ? n / 2 : n - 1;
               c2 = (c >= 0 && c + 2 < n) ? c + 2 : -1;
               for (int k = 0; k < 2; k++) begin
                  run_frame(al, n, c, c2, k[0]);
               end
            end
         end
      end

      // R7 and R8 at the edge of the position field
      run_frame(0, 40, 30, 33, 1'b0);
      run_frame(0, 40, 31, -1, 1'b1);
      run_frame(5, 40, 34, 35, 1'b0);

      // R9: abandoned frame with a collision, then a restart
      @(negedge clk);
      start_i = 1'b1; align_i = 3'd2; keep_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 5; i++) begin
         bit_vld_i = 1'b1; bit_dat_i = 1'b1; bit_coll_i = (i == 1);
         @(negedge clk);
         chk(wr_o == 1'b0, "R9", "no write in short frame", int'(wr_o), 0);
      end
      bit_vld_i = 1'b0; bit_coll_i = 1'b0;
      @(negedge clk);
      chk(coll_pos_o == 5'd2 && !coll_pos_inv_o, "R7", "position before restart", int'(coll_pos_o), 2);
      run_frame(0, 8, -1, -1, 1'b1);
      run_frame(3, 3, -1, -1, 1'b1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule